// File: doc/BRIEF.md
# Processor Special-Register Bank with Write Hooks

This block holds the special-purpose registers of a small 32-bit core. The core reaches it through one port: a 16-bit register number, a write strobe with 32-bit data, and a read strobe. Read data comes back registered one cycle later. Most register numbers are not plain storage. Writing certain numbers starts an action elsewhere in the core, and the stored value of some registers is reshaped on the way in.

Some numbers are cache command registers: a write sends the written address to the cache as a one-cycle command. The status register always keeps its fixed-one bit set. Turning interrupts on raises a strobe to the interrupt controller. The interrupt-status register takes writes only in edge-trigger mode. The next-PC register redirects the fetch unit. A window of 32 numbers reaches the general-purpose register file through a side port. The data-side and instruction-side translation-table entries drop their reserved bits. The power-management register can request suspend.

Top module: `spr_hook_bank`

## Requirements
- R1: After reset, every register reads 0 except the status register, which reads 0x00008000. rdValid, cmdValid, intEnPulse, pcLoad and suspendReq are all low.
- R2: A read strobe in cycle N gives rdValid high and rdData in cycle N+1. A write in cycle N is visible to a read issued in cycle N+1. A read in the same cycle as a write to the same number returns the old value. Numbers outside the map read 0, and writes to them change nothing.
- R3: Writing any of 0x1802 (dcache prefetch, kind 0), 0x1804 (dcache invalidate, kind 2), 0x1805 (dcache writeback, kind 3), 0x1806 (dcache lock, kind 4), 0x2002 (icache prefetch, kind 5), 0x2003 (icache invalidate, kind 6) or 0x2004 (icache lock, kind 7) gives a one-cycle cmdValid in the next cycle. In that cycle cmdKind carries the listed code and cmdAddr carries the written value. These registers always read 0.
- R4: Writing 0x1803 (dcache flush) gives a cmdValid pulse with kind 1 and the written address. From then on the register reads 0xFFFFFFFF; before any write it reads 0.
- R5: The status register (0x0011) always has bit 15 set, whatever value is written. All other bits are stored as written.
- R6: intEnPulse goes high for one cycle after a status write that takes bit 2 (interrupt enable) from 0 to 1. It also goes high after any write to the interrupt-mask register (0x4800) made while bit 2 is already 1. Rewriting bit 2 as 1 when it is already 1 gives no pulse.
- R7: A write to the interrupt-status register (0x4802) is stored only while edgeMode is 1. While edgeMode is 0 the previous value stays.
- R8: Numbers 0x0400 to 0x041F reach general-purpose registers 0 to 31. A write drives gprWe, gprAddr and gprWdata in the same cycle. A read returns gprRdata one cycle later.
- R9: Writing the next-PC register (0x0010) gives a one-cycle pcLoad in the next cycle, with pcLoadValue equal to the value and fetchNext equal to the value plus 4. The pcLoad pulse also cancels any pending delay-slot branch. A read of 0x0010 returns pcIn as it was in the read cycle.
- R10: Translation registers sit at base 0x0800 (data side) or 0x0A00 (instruction side), plus way*0x100 plus set, where set is bits 6:0 and must be below TLB_SETS. An offset with bit 7 clear is a match entry. A match entry stores only bits 31:13 (page) and 7:0 (valid bit 0, privilege bit 1, context 5:2, LRU 7:6).
- R11: An offset with bit 7 set is a translate entry. A data-side translate entry stores bits 31:13 and 9:0: coherency, inhibit, writeback, weak order, accessed, dirty, then four permission bits. An instruction-side translate entry stores bits 31:13 and 7:0. A set number at or above TLB_SETS reads 0 and ignores writes.
- R12: The power-management register (0x4000) stores all bits. suspendReq follows its bit 4, from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| regNum | input | 16 | Register number |
| wrData | input | 32 | Write data |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| rdData | output | 32 | Registered read data |
| pcIn | input | 32 | Current program counter |
| pcLoad | output | 1 | Redirect pulse, also cancels a pending delay-slot branch |
| pcLoadValue | output | 32 | New program counter |
| fetchNext | output | 32 | Following fetch address |
| edgeMode | input | 1 | Interrupt controller is in edge-trigger mode |
| intEnPulse | output | 1 | Interrupts-enabled strobe |
| suspendReq | output | 1 | Suspend request |
| cmdValid | output | 1 | Cache command pulse |
| cmdKind | output | 3 | Cache command code |
| cmdAddr | output | 32 | Cache command target address |
| gprAddr | output | 5 | General register index |
| gprWe | output | 1 | General register write enable |
| gprWdata | output | 32 | General register write data |
| gprRdata | input | 32 | General register read data for gprAddr |

## Verification
The bench builds the bank with TLB_WAYS=2 and TLB_SETS=4. With two ways, both way 0 and way 1 on each side can be reached. With only four sets, set numbers 4 and above fall outside the array even though they are inside the number window, so the ignore path gets exercised. These values also keep all 32 translation entries cheap enough that a stream of mixed operations can revisit every one of them.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam logic [15:0] NUM_NPC       = 16'h0010;
  localparam logic [15:0] NUM_SR        = 16'h0011;
  localparam logic [15:0] NUM_PMR       = 16'h4000;
  localparam logic [15:0] NUM_PICMR     = 16'h4800;
  localparam logic [15:0] NUM_PICSR     = 16'h4802;
  localparam logic [15:0] NUM_DC_PREF   = 16'h1802;
  localparam logic [15:0] NUM_DC_FLUSH  = 16'h1803;
  localparam logic [15:0] NUM_DC_INV    = 16'h1804;
  localparam logic [15:0] NUM_DC_WB     = 16'h1805;
  localparam logic [15:0] NUM_DC_LOCK   = 16'h1806;
  localparam logic [15:0] NUM_IC_PREF   = 16'h2002;
  localparam logic [15:0] NUM_IC_INV    = 16'h2003;
  localparam logic [15:0] NUM_IC_LOCK   = 16'h2004;
  localparam logic [15:0] NUM_GPR_BASE  = 16'h0400;
  localparam logic [15:0] NUM_DTLB_BASE = 16'h0800;
  localparam logic [15:0] NUM_ITLB_BASE = 16'h0A00;

  localparam int SR_FIXED  = 15;
  localparam int SR_INTEN  = 2;
  localparam int PMR_SUSP  = 4;
  localparam logic [31:0] SR_RESET = 32'h0000_8000;

  localparam logic [31:0] KEEP_MATCH  = 32'hFFFF_E0FF;
  localparam logic [31:0] KEEP_DXLATE = 32'hFFFF_E3FF;
  localparam logic [31:0] KEEP_IXLATE = 32'hFFFF_E0FF;

  typedef enum logic [2:0] {
    CMD_DC_PREF, CMD_DC_FLUSH, CMD_DC_INV, CMD_DC_WB,
    CMD_DC_LOCK, CMD_IC_PREF, CMD_IC_INV, CMD_IC_LOCK
  } cacheCmd_e;

  typedef enum logic [3:0] {
    RD_ZERO, RD_SR, RD_NPC, RD_PICMR, RD_PICSR, RD_PMR, RD_FLUSH, RD_GPR, RD_TLB
  } rdSel_e;

  typedef struct packed {
    logic      wrSr;
    logic      wrNpc;
    logic      wrPicmr;
    logic      wrPicsr;
    logic      wrPmr;
    logic      wrTlb;
    logic      wrGpr;
    logic      cmdFire;
    logic      wrFlush;
    cacheCmd_e cmdKind;
    logic      tlbInstr;
    logic      tlbXlate;
    rdSel_e    rdSel;
  } sprStrb_t;
endpackage

// File: rtl/spr_ctrl.sv
module spr_ctrl
  import spr_pkg::*;
#(
  parameter int TLB_WAYS = 2,
  parameter int TLB_SETS = 4,
  localparam int TLB_ENTRIES = 4 * TLB_WAYS * TLB_SETS,
  localparam int IDX_W = $clog2(TLB_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [15:0]      regNum,
  output sprStrb_t         strb,
  output logic [IDX_W-1:0] tlbIdx
);
  logic dSide, iSide, wayBit, xlBit, tlbHit;
  logic [6:0] setNum;
  rdSel_e sel;
  logic isCmd;
  cacheCmd_e kind;

  assign dSide  = regNum[15:9] == NUM_DTLB_BASE[15:9];
  assign iSide  = regNum[15:9] == NUM_ITLB_BASE[15:9];
  assign wayBit = regNum[8];
  assign xlBit  = regNum[7];
  assign setNum = regNum[6:0];
  assign tlbHit = (dSide || iSide) && (int'(wayBit) < TLB_WAYS) && (int'(setNum) < TLB_SETS);
  assign tlbIdx = IDX_W'(((int'(iSide) * TLB_WAYS + int'(wayBit)) * 2 + int'(xlBit)) * TLB_SETS
                         + int'(setNum));

  always_comb begin
    sel   = RD_ZERO;
    isCmd = 1'b0;
    kind  = CMD_DC_PREF;
    case (regNum)
      NUM_SR:       sel = RD_SR;
      NUM_NPC:      sel = RD_NPC;
      NUM_PICMR:    sel = RD_PICMR;
      NUM_PICSR:    sel = RD_PICSR;
      NUM_PMR:      sel = RD_PMR;
      NUM_DC_FLUSH: begin sel = RD_FLUSH; isCmd = 1'b1; kind = CMD_DC_FLUSH; end
      NUM_DC_PREF:  begin isCmd = 1'b1; kind = CMD_DC_PREF; end
      NUM_DC_INV:   begin isCmd = 1'b1; kind = CMD_DC_INV;  end
      NUM_DC_WB:    begin isCmd = 1'b1; kind = CMD_DC_WB;   end
      NUM_DC_LOCK:  begin isCmd = 1'b1; kind = CMD_DC_LOCK; end
      NUM_IC_PREF:  begin isCmd = 1'b1; kind = CMD_IC_PREF; end
      NUM_IC_INV:   begin isCmd = 1'b1; kind = CMD_IC_INV;  end
      NUM_IC_LOCK:  begin isCmd = 1'b1; kind = CMD_IC_LOCK; end
      default: begin
        if (regNum[15:5] == NUM_GPR_BASE[15:5]) sel = RD_GPR;
        else if (tlbHit) sel = RD_TLB;
      end
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.rdSel    = sel;
    strb.cmdKind  = kind;
    strb.tlbInstr = iSide;
    strb.tlbXlate = xlBit;
    strb.wrSr     = wrEn && sel == RD_SR;
    strb.wrNpc    = wrEn && sel == RD_NPC;
    strb.wrPicmr  = wrEn && sel == RD_PICMR;
    strb.wrPicsr  = wrEn && sel == RD_PICSR;
    strb.wrPmr    = wrEn && sel == RD_PMR;
    strb.wrTlb    = wrEn && sel == RD_TLB;
    strb.wrGpr    = wrEn && sel == RD_GPR;
    strb.cmdFire  = wrEn && isCmd;
    strb.wrFlush  = wrEn && sel == RD_FLUSH;
  end

  // R2: a single write lands on at most one hook
  assert_one_hook_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSr, strb.wrNpc, strb.wrPicmr, strb.wrPicsr, strb.wrPmr,
              strb.wrTlb, strb.wrGpr, strb.cmdFire}));
endmodule

// File: rtl/spr_dpath.sv
module spr_dpath
  import spr_pkg::*;
#(
  parameter int TLB_WAYS = 2,
  parameter int TLB_SETS = 4,
  localparam int TLB_ENTRIES = 4 * TLB_WAYS * TLB_SETS,
  localparam int IDX_W = $clog2(TLB_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  sprStrb_t         strb,
  input  logic [IDX_W-1:0] tlbIdx,
  input  logic             rdEn,
  input  logic [31:0]      wrData,
  input  logic [31:0]      pcIn,
  input  logic             edgeMode,
  input  logic [31:0]      gprRdata,
  output logic             rdValid,
  output logic [31:0]      rdData,
  output logic             pcLoad,
  output logic [31:0]      pcLoadValue,
  output logic [31:0]      fetchNext,
  output logic             intEnPulse,
  output logic             suspendReq,
  output logic             cmdValid,
  output logic [2:0]       cmdKind,
  output logic [31:0]      cmdAddr
);
  logic [31:0] srReg, picmrReg, picsrReg, pmrReg;
  logic        flushSeen;
  logic [31:0] tlbMem [TLB_ENTRIES];
  logic [31:0] tlbKeep, rdMux;

  always_comb begin
    if (!strb.tlbXlate)     tlbKeep = KEEP_MATCH;
    else if (strb.tlbInstr) tlbKeep = KEEP_IXLATE;
    else                    tlbKeep = KEEP_DXLATE;
  end

  always_comb begin
    case (strb.rdSel)
      RD_SR:    rdMux = srReg;
      RD_NPC:   rdMux = pcIn;
      RD_PICMR: rdMux = picmrReg;
      RD_PICSR: rdMux = picsrReg;
      RD_PMR:   rdMux = pmrReg;
      RD_FLUSH: rdMux = flushSeen ? 32'hFFFF_FFFF : 32'h0;
      RD_GPR:   rdMux = gprRdata;
      RD_TLB:   rdMux = tlbMem[tlbIdx];
      default:  rdMux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srReg     <= SR_RESET;
      picmrReg  <= '0;
      picsrReg  <= '0;
      pmrReg    <= '0;
      flushSeen <= 1'b0;
      for (int i = 0; i < TLB_ENTRIES; i++) tlbMem[i] <= '0;
    end else begin
      if (strb.wrSr)    srReg    <= wrData | (32'h1 << SR_FIXED);
      if (strb.wrPicmr) picmrReg <= wrData;
      if (strb.wrPicsr && edgeMode) picsrReg <= wrData;
      if (strb.wrPmr)   pmrReg   <= wrData;
      if (strb.wrFlush) flushSeen <= 1'b1;
      if (strb.wrTlb)   tlbMem[tlbIdx] <= wrData & tlbKeep;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid     <= 1'b0;
      rdData      <= '0;
      pcLoad      <= 1'b0;
      pcLoadValue <= '0;
      fetchNext   <= '0;
      intEnPulse  <= 1'b0;
      cmdValid    <= 1'b0;
      cmdKind     <= '0;
      cmdAddr     <= '0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= rdMux;
      pcLoad <= strb.wrNpc;
      if (strb.wrNpc) begin
        pcLoadValue <= wrData;
        fetchNext   <= wrData + 32'd4;
      end
      intEnPulse <= (strb.wrSr && wrData[SR_INTEN] && !srReg[SR_INTEN])
                 || (strb.wrPicmr && srReg[SR_INTEN]);
      cmdValid <= strb.cmdFire;
      if (strb.cmdFire) begin
        cmdKind <= strb.cmdKind;
        cmdAddr <= wrData;
      end
    end
  end

  assign suspendReq = pmrReg[PMR_SUSP];

  // R2: read data arrives one cycle after the strobe
  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
  // R3: every command write yields a pulse in the next cycle
  assert_cmd_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmdFire |=> cmdValid);
  // R5: fixed-one status bit never drops
  assert_sr_fixed_R5: assert property (@(posedge clk) disable iff (!rstN)
    srReg[SR_FIXED]);
  // R7: level mode freezes interrupt status
  assert_picsr_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !edgeMode |=> $stable(picsrReg));
  // R9: redirect carries the following fetch address
  assert_fetch_next_R9: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> fetchNext == pcLoadValue + 32'd4);
endmodule

// File: rtl/spr_hook_bank.sv
module spr_hook_bank
  import spr_pkg::*;
#(
  parameter int TLB_WAYS = 2,
  parameter int TLB_SETS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [15:0] regNum,
  input  logic [31:0] wrData,
  output logic        rdValid,
  output logic [31:0] rdData,
  input  logic [31:0] pcIn,
  output logic        pcLoad,
  output logic [31:0] pcLoadValue,
  output logic [31:0] fetchNext,
  input  logic        edgeMode,
  output logic        intEnPulse,
  output logic        suspendReq,
  output logic        cmdValid,
  output logic [2:0]  cmdKind,
  output logic [31:0] cmdAddr,
  output logic [4:0]  gprAddr,
  output logic        gprWe,
  output logic [31:0] gprWdata,
  input  logic [31:0] gprRdata
);
  localparam int TLB_ENTRIES = 4 * TLB_WAYS * TLB_SETS;
  localparam int IDX_W = $clog2(TLB_ENTRIES);

  sprStrb_t         strb;
  logic [IDX_W-1:0] tlbIdx;

  spr_ctrl #(.TLB_WAYS(TLB_WAYS), .TLB_SETS(TLB_SETS)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regNum(regNum), .strb(strb), .tlbIdx(tlbIdx)
  );

  spr_dpath #(.TLB_WAYS(TLB_WAYS), .TLB_SETS(TLB_SETS)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .tlbIdx(tlbIdx), .rdEn(rdEn), .wrData(wrData),
    .pcIn(pcIn), .edgeMode(edgeMode), .gprRdata(gprRdata), .rdValid(rdValid),
    .rdData(rdData), .pcLoad(pcLoad), .pcLoadValue(pcLoadValue), .fetchNext(fetchNext),
    .intEnPulse(intEnPulse), .suspendReq(suspendReq), .cmdValid(cmdValid),
    .cmdKind(cmdKind), .cmdAddr(cmdAddr)
  );

  assign gprAddr  = regNum[4:0];
  assign gprWe    = strb.wrGpr;
  assign gprWdata = wrData;

  // R8: the side port writes only inside the alias window
  assert_gpr_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    gprWe |-> (wrEn && regNum[15:5] == NUM_GPR_BASE[15:5]));
endmodule

// File: tb/sim_spr_hook_bank.sv
`timescale 1ns/1ps
module sim_spr_hook_bank;
  localparam int WAYS = 2;
  localparam int SETS = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, edgeMode = 1'b0;
  logic [15:0] regNum = '0;
  logic [31:0] wrData = '0, pcIn = '0;
  logic rdValid, pcLoad, intEnPulse, suspendReq, cmdValid, gprWe;
  logic [31:0] rdData, pcLoadValue, fetchNext, cmdAddr, gprWdata, gprRdata;
  logic [2:0] cmdKind;
  logic [4:0] gprAddr;
  logic [31:0] gprMem [32];

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spr_hook_bank #(.TLB_WAYS(WAYS), .TLB_SETS(SETS)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regNum(regNum), .wrData(wrData),
    .rdValid(rdValid), .rdData(rdData), .pcIn(pcIn), .pcLoad(pcLoad),
    .pcLoadValue(pcLoadValue), .fetchNext(fetchNext), .edgeMode(edgeMode),
    .intEnPulse(intEnPulse), .suspendReq(suspendReq), .cmdValid(cmdValid),
    .cmdKind(cmdKind), .cmdAddr(cmdAddr), .gprAddr(gprAddr), .gprWe(gprWe),
    .gprWdata(gprWdata), .gprRdata(gprRdata)
  );

  assign gprRdata = gprMem[gprAddr];
  always @(posedge clk) if (gprWe) gprMem[gprAddr] <= gprWdata;

  // reference model state
  logic [31:0] mSr, mPicmr, mPicsr, mPmr;
  bit mFlush;
  logic [31:0] mGpr [32];
  logic [31:0] mTlb [int];
  // expected outputs after the next edge
  bit eRdValid, eCmdValid, eInt, ePcLoad, eSusp;
  logic [31:0] eRdData, eCmdAddr, ePcVal, eFetch;
  int eCmdKind;

  function automatic int tlbKey(logic [15:0] n);
    bit d = n[15:9] == 7'h04;
    bit i = n[15:9] == 7'h05;
    if (!(d || i)) return -1;
    if (int'(n[8]) >= WAYS || int'(n[6:0]) >= SETS) return -1;
    return int'(n);
  endfunction

  function automatic logic [31:0] tlbMask(logic [15:0] n);
    if (!n[7]) return 32'hFFFF_E0FF;
    if (n[15:9] == 7'h05) return 32'hFFFF_E0FF;
    return 32'hFFFF_E3FF;
  endfunction

  function automatic int cmdCode(logic [15:0] n);
    case (n)
      16'h1802: return 0; 16'h1803: return 1; 16'h1804: return 2; 16'h1805: return 3;
      16'h1806: return 4; 16'h2002: return 5; 16'h2003: return 6; 16'h2004: return 7;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [31:0] mRead(logic [15:0] n);
    int k;
    case (n)
      16'h0011: return mSr;
      16'h0010: return pcIn;
      16'h4800: return mPicmr;
      16'h4802: return mPicsr;
      16'h4000: return mPmr;
      16'h1803: return mFlush ? 32'hFFFF_FFFF : 32'h0;
      default: ;
    endcase
    if (n >= 16'h0400 && n < 16'h0420) return mGpr[n - 16'h0400];
    k = tlbKey(n);
    if (k >= 0) return mTlb.exists(k) ? mTlb[k] : 32'h0;
    return 32'h0;
  endfunction

  task automatic mWrite(logic [15:0] n, logic [31:0] d);
    int k = tlbKey(n);
    int c = cmdCode(n);
    if (c >= 0) begin
      eCmdValid = 1; eCmdKind = c; eCmdAddr = d;
      if (c == 1) mFlush = 1;
    end
    case (n)
      16'h0011: begin
        if (d[2] && !mSr[2]) eInt = 1;
        mSr = d | 32'h8000;
      end
      16'h0010: begin ePcLoad = 1; ePcVal = d; eFetch = d + 4; end
      16'h4800: begin if (mSr[2]) eInt = 1; mPicmr = d; end
      16'h4802: if (edgeMode) mPicsr = d;
      16'h4000: mPmr = d;
      default: ;
    endcase
    if (n >= 16'h0400 && n < 16'h0420) mGpr[n - 16'h0400] = d;
    if (k >= 0) mTlb[k] = d & tlbMask(n);
  endtask

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(rdValid == eRdValid, tag, "rdValid", 32'(rdValid), 32'(eRdValid));
    if (eRdValid) chk(rdData == eRdData, tag, "rdData", rdData, eRdData);
    chk(cmdValid == eCmdValid, tag, "cmdValid", 32'(cmdValid), 32'(eCmdValid));
    if (eCmdValid) begin
      chk(int'(cmdKind) == eCmdKind, tag, "cmdKind", 32'(cmdKind), 32'(eCmdKind));
      chk(cmdAddr == eCmdAddr, tag, "cmdAddr", cmdAddr, eCmdAddr);
    end
    chk(intEnPulse == eInt, tag, "intEnPulse", 32'(intEnPulse), 32'(eInt));
    chk(pcLoad == ePcLoad, tag, "pcLoad", 32'(pcLoad), 32'(ePcLoad));
    if (ePcLoad) begin
      chk(pcLoadValue == ePcVal, tag, "pcLoadValue", pcLoadValue, ePcVal);
      chk(fetchNext == eFetch, tag, "fetchNext", fetchNext, eFetch);
    end
    chk(suspendReq == eSusp, tag, "suspendReq", 32'(suspendReq), 32'(eSusp));
  endtask

  task automatic step(bit we, bit re, logic [15:0] n, logic [31:0] d, string tag);
    wrEn = we; rdEn = re; regNum = n; wrData = d;
    eRdValid = re; eCmdValid = 0; eInt = 0; ePcLoad = 0;
    if (re) eRdData = mRead(n);
    if (we) mWrite(n, d);
    eSusp = mPmr[4];
    @(negedge clk);
    compare(tag);
    wrEn = 0; rdEn = 0;
  endtask

  task automatic wr(logic [15:0] n, logic [31:0] d, string tag);
    step(1, 0, n, d, tag);
  endtask

  task automatic rd(logic [15:0] n, string tag);
    step(0, 1, n, 32'h0, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] pool [16];
    logic [31:0] lfsr = 32'hACE1_2468;
    for (int i = 0; i < 32; i++) begin
      gprMem[i] = 32'h1111_0000 + 32'(i);
      mGpr[i]   = 32'h1111_0000 + 32'(i);
    end
    mSr = 32'h8000; mPicmr = 0; mPicsr = 0; mPmr = 0; mFlush = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    eRdValid = 0; eCmdValid = 0; eInt = 0; ePcLoad = 0; eSusp = 0;
    compare("R1");
    rd(16'h0011, "R1");
    rd(16'h4800, "R1");
    rd(16'h0883, "R1");

    wr(16'h0011, 32'h0000_0000, "R5");
    rd(16'h0011, "R5");
    wr(16'h0011, 32'h1234_0001, "R5");
    step(1, 1, 16'h0011, 32'h0000_0004, "R2");
    rd(16'h0011, "R6");
    wr(16'h0011, 32'h0000_0004, "R6");
    wr(16'h4800, 32'h0000_00F0, "R6");
    wr(16'h0011, 32'h0000_0000, "R6");
    wr(16'h4800, 32'h0000_000F, "R6");
    rd(16'h4800, "R6");

    edgeMode = 0;
    wr(16'h4802, 32'h0000_0055, "R7");
    rd(16'h4802, "R7");
    edgeMode = 1;
    wr(16'h4802, 32'h0000_0055, "R7");
    rd(16'h4802, "R7");
    edgeMode = 0;

    rd(16'h1803, "R4");
    wr(16'h1803, 32'h0000_4440, "R4");
    rd(16'h1803, "R4");
    wr(16'h1802, 32'h0000_1000, "R3"); rd(16'h1802, "R3");
    wr(16'h1804, 32'h0000_2000, "R3"); rd(16'h1804, "R3");
    wr(16'h1805, 32'h0000_3000, "R3"); rd(16'h1805, "R3");
    wr(16'h1806, 32'h0000_4000, "R3"); rd(16'h1806, "R3");
    wr(16'h2002, 32'h0000_5000, "R3"); rd(16'h2002, "R3");
    wr(16'h2003, 32'h0000_6000, "R3"); rd(16'h2003, "R3");
    wr(16'h2004, 32'h0000_7000, "R3"); rd(16'h2004, "R3");

    wr(16'h0405, 32'hDEAD_BEEF, "R8");
    rd(16'h0405, "R8");
    rd(16'h041F, "R8");
    rd(16'h0400, "R8");

    wr(16'h0010, 32'h0000_0100, "R9");
    pcIn = 32'h0000_2468;
    rd(16'h0010, "R9");

    wr(16'h0800, 32'hFFFF_FFFF, "R10"); rd(16'h0800, "R10");
    wr(16'h0A03, 32'hFFFF_FFFF, "R10"); rd(16'h0A03, "R10");
    wr(16'h0880, 32'hFFFF_FFFF, "R11"); rd(16'h0880, "R11");
    wr(16'h0B83, 32'hFFFF_FFFF, "R11"); rd(16'h0B83, "R11");
    wr(16'h0804, 32'hFFFF_FFFF, "R11"); rd(16'h0804, "R11");

    wr(16'h4000, 32'h0000_000F, "R12"); rd(16'h4000, "R12");
    wr(16'h4000, 32'h0000_0010, "R12"); rd(16'h4000, "R12");
    wr(16'h4000, 32'h0000_0000, "R12");

    wr(16'h3333, 32'h0000_0077, "R2");
    rd(16'h3333, "R2");

    pool = '{16'h0011, 16'h4800, 16'h4802, 16'h4000, 16'h0010, 16'h1803, 16'h1804,
             16'h2003, 16'h0403, 16'h041E, 16'h0801, 16'h0882, 16'h0902, 16'h0A81,
             16'h0B00, 16'h0985};
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      edgeMode = lfsr[9];
      pcIn = lfsr ^ 32'h5A5A_0000;
      step(lfsr[4], lfsr[5], pool[lfsr[3:0]], {lfsr[15:0], lfsr[31:16]} & 32'hFFFF_FFEF,
           "R2");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule